// File: doc/BRIEF.md
# Processor Control Register Bank

A small host-facing register file that sits beside a 32-bit programmable core. It holds eight 32-bit registers that the host processor uses to set up and control the core: a status/flag word, two matrix setup words, a data-ordering word, the program counter, a run/command word, an upper-data word and a divider control word. The host reaches them over a simple synchronous bus that carries a 5-bit byte address, a size code, a write enable and 32-bit data. Read data appears one clock after the request. Bytes are numbered big-endian within each word.

A write narrower than 32 bits merges the new lanes into the current readback value of the word and stores the result. Each register then applies its own rules. The pointer word drops its two low bits. The command word protects its interrupt-latch and version fields, and turns two command bits into one-cycle strobes instead of storing them. The flag word returns the core's live condition bits and hides its latch-clear field. The top word reads a remainder supplied from outside, while writes to the same offset go to a separate divider control register. The run bit and the two interrupt strobes are brought out as pins.

Top module: `proc_ctrl_regs`

## Requirements
- R1: After reset, the program counter is 0x00F03000, the command word is 0x00002800, the data-ordering word is 0xFFFFFFFF, and every other register and `bus_rdata` is 0.
- R2: A 32-bit access (size code 2) with address bits [1:0] equal to 0 writes or reads the word at index `bus_addr[4:2]`. Word indices are: 0 flags, 1 matrix control, 2 matrix pointer, 3 data ordering, 4 program counter, 5 command, 6 upper data, 7 remainder/divider control. The read value is on `bus_rdata` in the cycle after the request and is held until the next read. A word write at an unaligned address is ignored, and a word read at one returns 0. Size code 3 writes nothing and reads 0.
- R3: Lanes are big-endian. Byte address offset 0 selects bits 31:24 and offset 3 selects bits 7:0. A halfword at offset 0 selects bits 31:16 and one at offset 2 selects bits 15:0. Byte data uses `bus_wdata[7:0]` and `bus_rdata[7:0]`, and halfword data uses bits 15:0, zero-extended on read. A partial write keeps the other lanes of the current readback value.
- R4: Bits 1:0 of the matrix pointer are stored as 0 on every write.
- R5: Command-word bits 6 to 10 (interrupt latches) and bits 12 to 15 (version) keep their value across host writes. All other bits are stored as written, except bits 1 and 2.
- R6: Writing 1 to command bit 1 makes `host_irq` high for exactly the one cycle after the write. The bit always reads back 0.
- R7: Writing 1 to command bit 2 makes `local_irq0` high for the one cycle after the write and sets latch bit 6. Bit 2 always reads back 0.
- R8: `run_en` equals command bit 0.
- R9: A flags read returns `live_zcn` in bits 2:0 and 0 in bits 13:9. All other bits are returned as stored. A pulse on `irq_req[k]` sets command latch bit 6+k. Writing the flags with bit 9+k set clears that latch, but a request arriving in the same cycle wins.
- R10: Reads of index 7 return `rem_in`. Writes to index 7, including partial ones that merge with the stored value, go to `divctl_out`.
- R11: A halfword write at an odd byte address changes no register. A halfword read at an odd address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_addr | input | 5 | Byte address inside the bank |
| bus_wdata | input | 32 | Write data, right-aligned for narrow sizes |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| live_zcn | input | 3 | Live zero/carry/negative bits from the core |
| rem_in | input | 32 | Divider remainder shown at index 7 |
| irq_req | input | 5 | Interrupt latch set requests |
| flags_out | output | 32 | Stored flag word |
| mtx_ctrl_out | output | 32 | Matrix control word |
| mtx_ptr_out | output | 32 | Matrix pointer word |
| data_org_out | output | 32 | Data-ordering word |
| pc_out | output | 32 | Program counter |
| ctrl_out | output | 32 | Command word |
| hidata_out | output | 32 | Upper data word |
| divctl_out | output | 32 | Divider control word |
| run_en | output | 1 | Run enable |
| host_irq | output | 1 | One-cycle interrupt strobe toward the host |
| local_irq0 | output | 1 | One-cycle strobe for local interrupt 0 |

## Verification
The hardest case to reach is a collision on the command latches. It needs a latch-clear write to the flag word in the same cycle as a request on the same latch. On top of that, the latch first has to be set either by a request pulse or by the bit-2 command. The stimulus builds this on purpose: it sets two latches, clears them from the flag word, then drives one request in the exact cycle of a second clear. Partial writes to the flag word are also hard to get right, because their merge base is the masked readback view and not the stored word. The random phase mixes byte writes into that word while the live condition bits change.

// File: rtl/proc_ctrl_pkg.sv
package proc_ctrl_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned LANES    = WORD_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        IX_FLAGS  = 3'd0,
        IX_MCTRL  = 3'd1,
        IX_MPTR   = 3'd2,
        IX_ORG    = 3'd3,
        IX_PC     = 3'd4,
        IX_CTRL   = 3'd5,
        IX_HIDATA = 3'd6,
        IX_DIVREM = 3'd7
    } reg_ix_e;

    typedef struct packed {
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] mctrl;
        logic [WORD_W-1:0] mptr;
        logic [WORD_W-1:0] org;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] hidata;
        logic [WORD_W-1:0] divctl;
        logic [WORD_W-1:0] rdata;
        logic              host_irq;
        logic              local_irq0;
    } pcr_state_t;
endpackage

// File: rtl/pcr_lane_merge.sv
module pcr_lane_merge
    import proc_ctrl_pkg::*;
(
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] wdata,
    input  logic [1:0]        offset,
    input  acc_size_e         size,
    output logic [WORD_W-1:0] new_word,
    output logic              accept
);
    logic [LANES-1:0]  lane_en;
    logic [WORD_W-1:0] rep_data;

    always_comb begin
        lane_en  = '0;
        rep_data = wdata;
        accept   = 1'b0;
        unique case (size)
            SZ_WORD: begin
                accept  = (offset == 2'd0);
                lane_en = '1;
            end
            SZ_HALF: begin
                accept   = ~offset[0];
                lane_en  = offset[1] ? 4'b0011 : 4'b1100;
                rep_data = {2{wdata[15:0]}};
            end
            SZ_BYTE: begin
                accept   = 1'b1;
                lane_en  = 4'b1000 >> offset;
                rep_data = {LANES{wdata[7:0]}};
            end
            default: begin
                accept = 1'b0;
            end
        endcase
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign new_word[8*k +: 8] = lane_en[k] ? rep_data[8*k +: 8] : old_word[8*k +: 8];
    end
endmodule

// File: rtl/pcr_read_view.sv
module pcr_read_view
    import proc_ctrl_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        offset,
    input  acc_size_e         size,
    output logic [WORD_W-1:0] data
);
    logic [4:0] shamt;

    always_comb begin
        data  = '0;
        shamt = 5'(({3'b0, 2'd3 - offset}) << 3);
        unique case (size)
            SZ_WORD: data = (offset == 2'd0) ? word : '0;
            SZ_HALF: begin
                if (!offset[0])
                    data = {16'b0, (offset[1] ? word[15:0] : word[31:16])};
            end
            SZ_BYTE: data = {24'b0, 8'(word >> shamt)};
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/proc_ctrl_regs.sv
module proc_ctrl_regs
    import proc_ctrl_pkg::*;
#(
    parameter logic [31:0] PC_RESET      = 32'h00F0_3000,
    parameter logic [31:0] CTRL_RESET    = 32'h0000_2800,
    parameter logic [31:0] ORG_RESET     = 32'hFFFF_FFFF,
    parameter logic [31:0] CTRL_KEEP     = 32'h0000_F7C0,
    parameter int unsigned N_IRQ         = 5,
    parameter int unsigned LATCH_LSB     = 6,
    parameter int unsigned FLAG_CLR_LSB  = 9,
    parameter int unsigned PTR_ALIGN     = 2
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [1:0]  bus_size,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [2:0]  live_zcn,
    input  logic [31:0] rem_in,
    input  logic [4:0]  irq_req,
    output logic [31:0] flags_out,
    output logic [31:0] mtx_ctrl_out,
    output logic [31:0] mtx_ptr_out,
    output logic [31:0] data_org_out,
    output logic [31:0] pc_out,
    output logic [31:0] ctrl_out,
    output logic [31:0] hidata_out,
    output logic [31:0] divctl_out,
    output logic        run_en,
    output logic        host_irq,
    output logic        local_irq0
);
    localparam logic [31:0] CMD_BITS  = 32'h0000_0006;
    localparam logic [31:0] FLAG_HIDE = ((32'd1 << N_IRQ) - 32'd1) << FLAG_CLR_LSB;
    localparam logic [31:0] PTR_MASK  = ~((32'd1 << PTR_ALIGN) - 32'd1);

    pcr_state_t st_q, st_d;

    reg_ix_e     ix;
    acc_size_e   acc_sz;
    logic [31:0] flags_view;
    logic [31:0] cur_view;
    logic [31:0] merge_base;
    logic [31:0] rd_val;
    logic [31:0] wr_word;
    logic        wr_ok;
    logic        do_wr;

    assign ix     = reg_ix_e'(bus_addr[4:2]);
    assign acc_sz = acc_size_e'(bus_size);
    assign do_wr  = bus_sel && bus_we && wr_ok;

    assign flags_view = {st_q.flags[31:3] & ~FLAG_HIDE[31:3], live_zcn};

    always_comb begin
        unique case (ix)
            IX_FLAGS:  cur_view = flags_view;
            IX_MCTRL:  cur_view = st_q.mctrl;
            IX_MPTR:   cur_view = st_q.mptr;
            IX_ORG:    cur_view = st_q.org;
            IX_PC:     cur_view = st_q.pc;
            IX_CTRL:   cur_view = st_q.ctrl;
            IX_HIDATA: cur_view = st_q.hidata;
            default:   cur_view = rem_in;
        endcase
        merge_base = (ix == IX_DIVREM) ? st_q.divctl : cur_view;
    end

    pcr_read_view u_rview (
        .word   (cur_view),
        .offset (bus_addr[1:0]),
        .size   (acc_sz),
        .data   (rd_val)
    );

    pcr_lane_merge u_merge (
        .old_word (merge_base),
        .wdata    (bus_wdata),
        .offset   (bus_addr[1:0]),
        .size     (acc_sz),
        .new_word (wr_word),
        .accept   (wr_ok)
    );

    always_comb begin
        logic [N_IRQ-1:0] lat_clr;
        logic [N_IRQ-1:0] lat_set;
        st_d            = st_q;
        st_d.host_irq   = 1'b0;
        st_d.local_irq0 = 1'b0;
        lat_clr         = '0;
        lat_set         = irq_req;

        if (bus_sel && !bus_we)
            st_d.rdata = rd_val;

        if (do_wr) begin
            unique case (ix)
                IX_FLAGS: begin
                    st_d.flags = wr_word;
                    lat_clr    = wr_word[FLAG_CLR_LSB +: N_IRQ];
                end
                IX_MCTRL:  st_d.mctrl  = wr_word;
                IX_MPTR:   st_d.mptr   = wr_word & PTR_MASK;
                IX_ORG:    st_d.org    = wr_word;
                IX_PC:     st_d.pc     = wr_word;
                IX_CTRL: begin
                    st_d.ctrl       = (st_q.ctrl & CTRL_KEEP) | (wr_word & ~CTRL_KEEP & ~CMD_BITS);
                    st_d.host_irq   = wr_word[1];
                    st_d.local_irq0 = wr_word[2];
                    lat_set[0]      = irq_req[0] | wr_word[2];
                end
                IX_HIDATA: st_d.hidata = wr_word;
                default:   st_d.divctl = wr_word;
            endcase
        end

        st_d.ctrl[LATCH_LSB +: N_IRQ] = (st_d.ctrl[LATCH_LSB +: N_IRQ] & ~lat_clr) | lat_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.pc         <= PC_RESET;
            st_q.ctrl       <= CTRL_RESET;
            st_q.org        <= ORG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata    = st_q.rdata;
    assign flags_out    = st_q.flags;
    assign mtx_ctrl_out = st_q.mctrl;
    assign mtx_ptr_out  = st_q.mptr;
    assign data_org_out = st_q.org;
    assign pc_out       = st_q.pc;
    assign ctrl_out     = st_q.ctrl;
    assign hidata_out   = st_q.hidata;
    assign divctl_out   = st_q.divctl;
    assign run_en       = st_q.ctrl[0];
    assign host_irq     = st_q.host_irq;
    assign local_irq0   = st_q.local_irq0;

    // R4: pointer writes never leave the low bits set
    a_r4_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && ix == IX_MPTR) |=> (mtx_ptr_out[1:0] == 2'b00));

    // R5: version field holds across any cycle
    a_r5_version_held: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(ctrl_out[15:12]));

    // R6: a host strobe only follows a bus write
    a_r6_strobe_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(bus_sel && bus_we));

    // R7: the local strobe comes with latch 0 set
    a_r7_latch_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        local_irq0 |-> ctrl_out[LATCH_LSB]);

    // R11: odd halfword writes leave the data registers untouched
    a_r11_odd_half_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && acc_sz == SZ_HALF && bus_addr[0])
        |=> $stable({flags_out, mtx_ctrl_out, mtx_ptr_out, data_org_out,
                     pc_out, hidata_out, divctl_out}));
endmodule

// File: tb/proc_ctrl_regs_tb.sv
module proc_ctrl_regs_tb;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  live_zcn = 3'b000;
    logic [31:0] rem_in = '0;
    logic [4:0]  irq_req = '0;
    logic [31:0] flags_out, mtx_ctrl_out, mtx_ptr_out, data_org_out;
    logic [31:0] pc_out, ctrl_out, hidata_out, divctl_out;
    logic        run_en, host_irq, local_irq0;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    proc_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .live_zcn(live_zcn), .rem_in(rem_in),
        .irq_req(irq_req), .flags_out(flags_out), .mtx_ctrl_out(mtx_ctrl_out),
        .mtx_ptr_out(mtx_ptr_out), .data_org_out(data_org_out), .pc_out(pc_out),
        .ctrl_out(ctrl_out), .hidata_out(hidata_out), .divctl_out(divctl_out),
        .run_en(run_en), .host_irq(host_irq), .local_irq0(local_irq0)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_reg [8];    // index 7 holds divider control
    logic [31:0] m_rdata;
    bit          m_hirq, m_lirq;
    bit          m_valid = 0;

    function automatic logic [31:0] m_view(int idx, bit for_write);
        logic [31:0] v;
        if (idx == 7) return for_write ? m_reg[7] : rem_in;
        v = m_reg[idx];
        if (idx == 0) begin
            v[13:9] = 5'b0;
            v[2:0]  = live_zcn;
        end
        return v;
    endfunction

    always @(posedge clk) begin : ref_model
        int          idx, off;
        logic [31:0] w, v;
        bit          ok;
        logic [4:0]  clr, setb;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_reg[i] = 32'h0;
            m_reg[4] = 32'h00F03000;
            m_reg[5] = 32'h00002800;
            m_reg[3] = 32'hFFFFFFFF;
            m_rdata = 0; m_hirq = 0; m_lirq = 0;
            m_valid = 1;
        end else begin
            idx = int'(bus_addr) / 4;
            off = int'(bus_addr) % 4;
            m_hirq = 0; m_lirq = 0;
            clr = 0; setb = irq_req;
            if (bus_sel && !bus_we) begin
                v = m_view(idx, 0);
                if (bus_size == 2)      m_rdata = (off == 0) ? v : 0;
                else if (bus_size == 1) m_rdata = (off % 2 == 0) ? ((v >> (16 - 8*off)) & 32'hFFFF) : 0;
                else if (bus_size == 0) m_rdata = (v >> (24 - 8*off)) & 32'hFF;
                else                    m_rdata = 0;
            end
            if (bus_sel && bus_we) begin
                w  = m_view(idx, 1);
                ok = 0;
                if (bus_size == 2 && off == 0) begin w = bus_wdata; ok = 1; end
                if (bus_size == 1 && off % 2 == 0) begin
                    for (int b = 0; b < 2; b++) w[31 - 8*(off+b) -: 8] = bus_wdata[15 - 8*b -: 8];
                    ok = 1;
                end
                if (bus_size == 0) begin w[31 - 8*off -: 8] = bus_wdata[7:0]; ok = 1; end
                if (ok) begin
                    case (idx)
                        0: begin m_reg[0] = w; clr = w[13:9]; end
                        2: m_reg[2] = {w[31:2], 2'b00};
                        5: begin
                            for (int b = 0; b < 32; b++)
                                if (!((b >= 6 && b <= 10) || b >= 12 && b <= 15 || b == 1 || b == 2))
                                    m_reg[5][b] = w[b];
                            m_hirq = w[1];
                            m_lirq = w[2];
                            if (w[2]) setb[0] = 1;
                        end
                        default: m_reg[idx] = w;
                    endcase
                end
            end
            for (int k = 0; k < 5; k++) begin
                if (clr[k]) m_reg[5][6+k] = 0;
                if (setb[k]) m_reg[5][6+k] = 1;
            end
        end
    end

    task automatic cmp32(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%08h expected=%08h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && m_valid) begin
            cmp32(bus_rdata, m_rdata, "R2 R3 rdata");
            cmp32(flags_out, m_reg[0], "R9 flags");
            cmp32(mtx_ctrl_out, m_reg[1], "R2 mctrl");
            cmp32(mtx_ptr_out, m_reg[2], "R4 mptr");
            cmp32(data_org_out, m_reg[3], "R3 org");
            cmp32(pc_out, m_reg[4], "R1 pc");
            cmp32(ctrl_out, m_reg[5], "R5 ctrl");
            cmp32(hidata_out, m_reg[6], "R11 hidata");
            cmp32(divctl_out, m_reg[7], "R10 divctl");
            cmp32({29'b0, run_en, host_irq, local_irq0},
                  {29'b0, m_reg[5][0], m_hirq, m_lirq}, "R6 R7 R8 pins");
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [4:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; irq_req = 0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [1:0] sz,
                      input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a; bus_size = sz;
        @(negedge clk);
        bus_sel = 0;
        cmp32(bus_rdata, exp, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cmp32(pc_out, 32'h00F03000, "R1 pc reset");
        cmp32(ctrl_out, 32'h00002800, "R1 ctrl reset");
        cmp32(data_org_out, 32'hFFFFFFFF, "R1 org reset");
        cmp32({31'b0, run_en}, 0, "R8 run reset");
        rd(5'h10, 2, 32'h00F03000, "R1 pc read");

        wr(5'h04, 2, 32'h12345678);
        rd(5'h04, 2, 32'h12345678, "R2 word roundtrip");
        wr(5'h18, 2, 32'hCAFEF00D);
        wr(5'h05, 2, 32'hFFFFFFFF);
        rd(5'h04, 2, 32'h12345678, "R2 unaligned word write ignored");
        rd(5'h06, 2, 32'h0, "R2 unaligned word read zero");
        wr(5'h0C, 3, 32'h0);
        cmp32(data_org_out, 32'hFFFFFFFF, "R2 reserved size ignored");

        wr(5'h0D, 0, 32'h000000AB);
        cmp32(data_org_out, 32'hFFABFFFF, "R3 byte lane merge");
        rd(5'h0D, 0, 32'h000000AB, "R3 byte read");
        rd(5'h0C, 1, 32'h0000FFAB, "R3 upper half read");
        wr(5'h0E, 1, 32'h00001234);
        cmp32(data_org_out, 32'hFFAB1234, "R3 lower half merge");
        rd(5'h0F, 0, 32'h00000034, "R3 last byte read");

        wr(5'h08, 2, 32'hDEADBEEF);
        cmp32(mtx_ptr_out, 32'hDEADBEEC, "R4 pointer aligned");

        wr(5'h14, 2, 32'hFFFFFFF9);
        cmp32(ctrl_out, 32'hFFFF2839, "R5 protected fields");
        cmp32({31'b0, run_en}, 1, "R8 run set");
        wr(5'h14, 2, 32'h0);
        cmp32(ctrl_out, 32'h00002000, "R5 version kept");
        cmp32({31'b0, run_en}, 0, "R8 run clear");

        wr(5'h14, 2, 32'h2);
        cmp32({31'b0, host_irq}, 1, "R6 strobe high");
        cmp32(ctrl_out, 32'h00002000, "R6 bit not stored");
        @(negedge clk);
        cmp32({31'b0, host_irq}, 0, "R6 strobe one cycle");

        wr(5'h14, 2, 32'h4);
        cmp32({31'b0, local_irq0}, 1, "R7 strobe high");
        cmp32(ctrl_out, 32'h00002040, "R7 latch set");

        live_zcn = 3'b101;
        @(negedge clk); irq_req = 5'b01000;
        @(negedge clk); irq_req = 0;
        cmp32(ctrl_out, 32'h00002240, "R9 request sets latch");
        wr(5'h00, 2, 32'h00001203);
        cmp32(ctrl_out, 32'h00002000, "R9 flags clear latches");
        rd(5'h00, 2, 32'h00000005, "R9 flags view");
        @(negedge clk); irq_req = 5'b00010;
        @(negedge clk); irq_req = 0;
        irq_req = 5'b00010;
        wr(5'h00, 2, 32'h00000400);
        cmp32(ctrl_out, 32'h00002080, "R9 set wins over clear");

        rem_in = 32'h0BADC0DE;
        rd(5'h1C, 2, 32'h0BADC0DE, "R10 remainder read");
        wr(5'h1C, 2, 32'h55AA55AA);
        cmp32(divctl_out, 32'h55AA55AA, "R10 divider write");
        rd(5'h1C, 2, 32'h0BADC0DE, "R10 remainder still read");
        wr(5'h1F, 0, 32'h11);
        cmp32(divctl_out, 32'h55AA5511, "R10 partial merge on divider");

        wr(5'h19, 1, 32'h0000BEEF);
        cmp32(hidata_out, 32'hCAFEF00D, "R11 odd half write ignored");
        rd(5'h19, 1, 32'h0, "R11 odd half read zero");

        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            bus_sel   = $urandom_range(0, 1);
            bus_we    = $urandom_range(0, 1);
            bus_size  = 2'($urandom_range(0, 3));
            bus_addr  = 5'($urandom_range(0, 31));
            bus_wdata = $urandom;
            irq_req   = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'b0;
            live_zcn  = 3'($urandom);
            rem_in    = $urandom;
        end
        @(negedge clk);
        bus_sel = 0; irq_req = 0;
        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule